// File: doc/BRIEF.md
# Last-Chunk BLAKE-256 Nonce Search Engine

This block searches for a proof-of-work solution by hashing only the final 64-byte chunk of a block header. The host loads a precomputed 256-bit chaining value that already covers the earlier header bytes, together with fixed header words, an extended nonce word, a 16-bit starting nonce, a 16-bit step and a 32-bit threshold mask. All of these go through a byte-wide configuration port. A rising edge on the enable input starts the search. For each candidate nonce the engine runs the 14-round BLAKE-256 compression, one half-round per clock, and tests the two leading digest words against the target.

On a hit the engine stores the winning nonce, raises a sticky interrupt and goes idle. The host clears the interrupt with a one-cycle pulse. When adding the step to a nonce that missed would go past 0xFFFF, the engine stops and flags exhaustion without raising the interrupt. Dropping enable in the middle of a search abandons it.

Top module: `blake_nonce_search`

## Requirements
- R1: After reset, irq_o, busy_o and exhausted_o are 0 and sol_nonce_o is 0x0000.
- R2: Configuration byte map. Bytes 0x00-0x1F hold chaining words h0..h7, four bytes per word, with the lowest address as the most significant byte. Bytes 0x20-0x23 hold the threshold mask. Bytes 0x24-0x33 hold message words m0..m3. Bytes 0x34-0x37 hold the extended nonce m4. Bytes 0x38-0x39 hold the start nonce and bytes 0x3A-0x3B hold the step, most significant byte first.
- R3: Each attempt builds its message block as follows. m5 = {16'h0000, nonce}, m6 = 0x80000000, m13 = 0x00000001, m14 and m15 = the high and low halves of the 64-bit length LEN_BITS (1536 by default), and every other word is 0. The block is compressed by 14-round BLAKE-256 from h0..h7, with zero salt and counter = LEN_BITS. Digest word i is h_i ^ v_i ^ v_(i+8).
- R4: A candidate is a hit when the top TOP_ZERO_BITS bits of digest word 0 are zero (all 32 by default) and (digest word 1 AND mask) is zero.
- R5: A rising edge of enable_i while idle starts the search at the start nonce. Each miss advances the nonce by the step. The first hit sets irq_o, loads sol_nonce_o with that nonce and drops busy_o. sol_nonce_o changes only on a hit.
- R6: Every attempt takes 31 cycles. If attempt k (counting from 1) ends the search, busy_o is high for exactly 31*k cycles.
- R7: irq_o stays at 1 until an irq_clr_i pulse, which brings it to 0 on the next cycle.
- R8: When irq_clr_i coincides with the cycle in which a new hit is recorded, irq_o stays at 1 and sol_nonce_o takes the new nonce.
- R9: If the sum of a missing nonce and the step exceeds 0xFFFF, the search stops with exhausted_o = 1 and irq_o unchanged. The next start clears exhausted_o.
- R10: If enable_i goes low during a search, busy_o falls on the next cycle, and irq_o, exhausted_o and sol_nonce_o keep their values.
- R11: Configuration writes made while busy_o is 1 are ignored. Writes to addresses 0x3C and above are ignored.
- R12: Holding enable_i high after a search ends does not start a new search. Only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 6 | Configuration byte address |
| cfg_wdata_i | input | 8 | Configuration byte data |
| enable_i | input | 1 | Search enable; its rising edge starts a search |
| irq_clr_i | input | 1 | Clears the solution interrupt |
| irq_o | output | 1 | Sticky solution interrupt |
| sol_nonce_o | output | 16 | Nonce of the last hit |
| busy_o | output | 1 | Search in progress |
| exhausted_o | output | 1 | Last search ran out of nonce space |

## Verification
The interrupt clear and the recording of a new hit can land in the same cycle. To provoke this, the bench leaves the interrupt set from an earlier hit, predicts with its own hash model which attempt of the next search hits, and pulses the clear exactly in the cycle that result is registered. The bench passes this case only if the interrupt is still high afterwards and the solution register holds the new nonce. A second overlap, a configuration write arriving while a search runs, is judged by checking that the outcome matches the model computed from the configuration held before the write.

// File: rtl/blake_pkg.sv
package blake_pkg;

  typedef logic [15:0][31:0] blk_t;
  typedef logic [7:0][31:0]  chain_t;

  function automatic logic [31:0] blake_u(input logic [3:0] idx);
    case (idx)
      4'd0:  return 32'h243F6A88;
      4'd1:  return 32'h85A308D3;
      4'd2:  return 32'h13198A2E;
      4'd3:  return 32'h03707344;
      4'd4:  return 32'hA4093822;
      4'd5:  return 32'h299F31D0;
      4'd6:  return 32'h082EFA98;
      4'd7:  return 32'hEC4E6C89;
      4'd8:  return 32'h452821E6;
      4'd9:  return 32'h38D01377;
      4'd10: return 32'hBE5466CF;
      4'd11: return 32'h34E90C6C;
      4'd12: return 32'hC0AC29B7;
      4'd13: return 32'hC97C50DD;
      4'd14: return 32'h3F84D5B5;
      default: return 32'hB5470917;
    endcase
  endfunction

  // one permutation row per round, nibble 0 in the top bits
  function automatic logic [63:0] perm_row(input logic [3:0] row);
    case (row)
      4'd1: return 64'hEA489FD61C02B753;
      4'd2: return 64'hB8C052FDAE367194;
      4'd3: return 64'h7931DCBE265A40F8;
      4'd4: return 64'h905724AFE1BC683D;
      4'd5: return 64'h2C6A0B834D75FE19;
      4'd6: return 64'hC51FED4A0763928B;
      4'd7: return 64'hDB7EC13950F4862A;
      4'd8: return 64'h6FE9B308C2D714A5;
      4'd9: return 64'hA2847615FB9E3CD0;
      default: return 64'h0123456789ABCDEF;
    endcase
  endfunction

  function automatic logic [3:0] perm_at(input logic [3:0] row, input logic [3:0] pos);
    logic [63:0] sh;
    sh = perm_row(row) >> {(4'd15 - pos), 2'b00};
    return sh[3:0];
  endfunction

  function automatic logic [31:0] rotr32(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [127:0] mix_g(input logic [31:0] a0, b0, c0, d0, x, y);
    logic [31:0] a, b, c, d;
    a = a0 + b0 + x;
    d = rotr32(d0 ^ a, 16);
    c = c0 + d;
    b = rotr32(b0 ^ c, 12);
    a = a + b + y;
    d = rotr32(d ^ a, 8);
    c = c + d;
    b = rotr32(b ^ c, 7);
    return {a, b, c, d};
  endfunction

endpackage

// File: rtl/blake_half_round.sv
module blake_half_round
  import blake_pkg::*;
(
  input  blk_t       v_i,
  input  blk_t       m_i,
  input  logic [3:0] row_i,
  input  logic       diag_i,
  output blk_t       v_o
);

  logic [31:0] w [16];
  logic [31:0] r [16];

  // diagonal step = column step on a row-rotated view of the state
  for (genvar g = 0; g < 4; g++) begin : g_lane
    localparam logic [1:0] GI = 2'(g);
    localparam int B_FWD = 4 + ((g + 1) % 4);
    localparam int C_FWD = 8 + ((g + 2) % 4);
    localparam int D_FWD = 12 + ((g + 3) % 4);
    localparam int B_INV = 4 + ((g + 3) % 4);
    localparam int C_INV = 8 + ((g + 2) % 4);
    localparam int D_INV = 12 + ((g + 1) % 4);
    logic [3:0] s0, s1;

    assign w[g]      = v_i[g];
    assign w[4 + g]  = diag_i ? v_i[B_FWD] : v_i[4 + g];
    assign w[8 + g]  = diag_i ? v_i[C_FWD] : v_i[8 + g];
    assign w[12 + g] = diag_i ? v_i[D_FWD] : v_i[12 + g];

    assign s0 = perm_at(row_i, {diag_i, GI, 1'b0});
    assign s1 = perm_at(row_i, {diag_i, GI, 1'b1});

    assign {r[g], r[4 + g], r[8 + g], r[12 + g]} =
      mix_g(w[g], w[4 + g], w[8 + g], w[12 + g],
            m_i[s0] ^ blake_u(s1), m_i[s1] ^ blake_u(s0));

    assign v_o[g]      = r[g];
    assign v_o[4 + g]  = diag_i ? r[B_INV] : r[4 + g];
    assign v_o[8 + g]  = diag_i ? r[C_INV] : r[8 + g];
    assign v_o[12 + g] = diag_i ? r[D_INV] : r[12 + g];
  end

endmodule

// File: rtl/blake_iter_core.sv
module blake_iter_core
  import blake_pkg::*;
#(
  parameter int          ROUNDS   = 14,
  parameter logic [63:0] LEN_BITS = 64'd1536
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  chain_t      h_i,
  input  blk_t        m_i,
  output logic        done_o,
  output logic [31:0] dig0_o,
  output logic [31:0] dig1_o
);

  localparam int HALF = 2 * ROUNDS;
  localparam int CW   = $clog2(HALF + 1);

  logic          run_q, done_q;
  logic [CW-1:0] cnt_q;
  blk_t          v_q, v_nxt, v_init;
  logic [31:0]   dig0_q, dig1_q;
  logic [3:0]    row;

  assign row = 4'((32'(cnt_q) >> 1) % 32'd10);

  for (genvar i = 0; i < 8; i++) begin : g_init_h
    assign v_init[i] = h_i[i];
  end
  for (genvar i = 0; i < 4; i++) begin : g_init_c
    assign v_init[8 + i] = blake_u(4'(i));
  end
  assign v_init[12] = LEN_BITS[31:0]  ^ blake_u(4'd4);
  assign v_init[13] = LEN_BITS[31:0]  ^ blake_u(4'd5);
  assign v_init[14] = LEN_BITS[63:32] ^ blake_u(4'd6);
  assign v_init[15] = LEN_BITS[63:32] ^ blake_u(4'd7);

  blake_half_round i_half (
    .v_i    (v_q),
    .m_i    (m_i),
    .row_i  (row),
    .diag_i (cnt_q[0]),
    .v_o    (v_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      v_q    <= '0;
      dig0_q <= '0;
      dig1_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        v_q   <= v_init;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == CW'(HALF)) begin
          dig0_q <= h_i[0] ^ v_q[0] ^ v_q[8];
          dig1_q <= h_i[1] ^ v_q[1] ^ v_q[9];
          done_q <= 1'b1;
          run_q  <= 1'b0;
        end else begin
          v_q   <= v_nxt;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign dig0_o = dig0_q;
  assign dig1_o = dig1_q;

endmodule

// File: rtl/blake_nonce_search.sv
module blake_nonce_search
  import blake_pkg::*;
#(
  parameter int          ROUNDS        = 14,
  parameter int          TOP_ZERO_BITS = 32,
  parameter logic [63:0] LEN_BITS      = 64'd1536
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [5:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  input  logic        enable_i,
  input  logic        irq_clr_i,
  output logic        irq_o,
  output logic [15:0] sol_nonce_o,
  output logic        busy_o,
  output logic        exhausted_o
);

  localparam int CFG_BYTES  = 60;
  localparam int MASK_BASE  = 32;
  localparam int MSG_BASE   = 36;
  localparam int UPPER_BASE = 52;
  localparam int NONCE_BASE = 56;
  localparam int STEP_BASE  = 58;

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e      state_q;
  logic [7:0]  cfg_q [CFG_BYTES];
  logic        en_q, start_q, irq_q, exh_q;
  logic [15:0] nonce_q, sol_q;
  chain_t      h_w;
  blk_t        m_w;
  logic [31:0] mask_w, dig0, dig1;
  logic [15:0] nonce_start, step;
  logic [16:0] nonce_sum;
  logic        core_done, hit;

  for (genvar i = 0; i < 8; i++) begin : g_mid
    assign h_w[i] = {cfg_q[4*i], cfg_q[4*i+1], cfg_q[4*i+2], cfg_q[4*i+3]};
  end
  for (genvar i = 0; i < 5; i++) begin : g_msg
    localparam int B = MSG_BASE + 4*i;
    assign m_w[i] = {cfg_q[B], cfg_q[B+1], cfg_q[B+2], cfg_q[B+3]};
  end
  for (genvar i = 7; i < 13; i++) begin : g_pad
    assign m_w[i] = '0;
  end
  assign m_w[5]  = {16'h0000, nonce_q};
  assign m_w[6]  = 32'h8000_0000;
  assign m_w[13] = 32'h0000_0001;
  assign m_w[14] = LEN_BITS[63:32];
  assign m_w[15] = LEN_BITS[31:0];

  assign mask_w      = {cfg_q[MASK_BASE], cfg_q[MASK_BASE+1], cfg_q[MASK_BASE+2], cfg_q[MASK_BASE+3]};
  assign nonce_start = {cfg_q[NONCE_BASE], cfg_q[NONCE_BASE+1]};
  assign step        = {cfg_q[STEP_BASE], cfg_q[STEP_BASE+1]};
  assign nonce_sum   = {1'b0, nonce_q} + {1'b0, step};

  blake_iter_core #(
    .ROUNDS   (ROUNDS),
    .LEN_BITS (LEN_BITS)
  ) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .h_i     (h_w),
    .m_i     (m_w),
    .done_o  (core_done),
    .dig0_o  (dig0),
    .dig1_o  (dig1)
  );

  assign hit = (dig0[31 -: TOP_ZERO_BITS] == '0) && ((dig1 & mask_w) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CFG_BYTES; i++) cfg_q[i] <= '0;
    end else if (cfg_we_i && state_q == S_IDLE && cfg_addr_i < 6'(CFG_BYTES)) begin
      cfg_q[cfg_addr_i] <= cfg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      en_q    <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      exh_q   <= 1'b0;
      nonce_q <= '0;
      sol_q   <= '0;
    end else begin
      en_q    <= enable_i;
      start_q <= 1'b0;
      if (irq_clr_i) irq_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (enable_i && !en_q) begin
            nonce_q <= nonce_start;
            start_q <= 1'b1;
            exh_q   <= 1'b0;
            state_q <= S_RUN;
          end
        end
        default: begin
          if (!enable_i) begin
            state_q <= S_IDLE;
          end else if (core_done && !start_q) begin
            if (hit) begin
              irq_q   <= 1'b1;  // set beats a same-cycle clear
              sol_q   <= nonce_q;
              state_q <= S_IDLE;
            end else if (nonce_sum[16]) begin
              exh_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              nonce_q <= nonce_sum[15:0];
              start_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign irq_o       = irq_q;
  assign sol_nonce_o = sol_q;
  assign busy_o      = (state_q == S_RUN);
  assign exhausted_o = exh_q;

endmodule

module blake_nonce_search_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        enable_i,
  input logic        irq_clr_i,
  input logic        irq_o,
  input logic [15:0] sol_nonce_o,
  input logic        busy_o,
  input logic        exhausted_o
);

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o); // R7

  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_i && !busy_o |=> !irq_o); // R7

  AST_SOL_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sol_nonce_o) |-> irq_o); // R5

  AST_EXH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exhausted_o) |-> !$rose(irq_o) && !busy_o); // R9

  AST_START_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_i) && !busy_o |=> busy_o); // R5

  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !enable_i |=> !busy_o); // R10

endmodule

bind blake_nonce_search blake_nonce_search_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .irq_clr_i   (irq_clr_i),
  .irq_o       (irq_o),
  .sol_nonce_o (sol_nonce_o),
  .busy_o      (busy_o),
  .exhausted_o (exhausted_o)
);

// File: tb/test_blake_nonce_search.sv
module test_blake_nonce_search;

  localparam int TZB = 1;
  localparam logic [63:0] LEN = 64'd1536;
  localparam int K_HIT = 0, K_EXH = 1, K_ABORT = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [5:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        enable_i = 1'b0;
  logic        irq_clr_i = 1'b0;
  logic        irq_o, busy_o, exhausted_o;
  logic [15:0] sol_nonce_o;

  always #5 clk_i = ~clk_i;

  blake_nonce_search #(.TOP_ZERO_BITS(TZB)) i_blake_nonce_search (.*);

  typedef struct {
    int          kind;
    logic [15:0] nonce;
    int          cycles;
    logic        irq;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic [15:0] last_sol = '0;
  bit done = 0;

  logic [31:0] mid [8];
  logic [31:0] stat [4];
  logic [31:0] upper, mask;
  logic [15:0] nst, strd;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic int sg(input int r, input int p);
    logic [63:0] t;
    case (r)
      0: t = 64'h0123456789ABCDEF; 1: t = 64'hEA489FD61C02B753;
      2: t = 64'hB8C052FDAE367194; 3: t = 64'h7931DCBE265A40F8;
      4: t = 64'h905724AFE1BC683D; 5: t = 64'h2C6A0B834D75FE19;
      6: t = 64'hC51FED4A0763928B; 7: t = 64'hDB7EC13950F4862A;
      8: t = 64'h6FE9B308C2D714A5; default: t = 64'hA2847615FB9E3CD0;
    endcase
    return int'((t >> (4 * (15 - p))) & 64'hF);
  endfunction

  function automatic logic [31:0] kc(input int i);
    logic [31:0] k [16];
    k = '{32'h243F6A88, 32'h85A308D3, 32'h13198A2E, 32'h03707344,
          32'hA4093822, 32'h299F31D0, 32'h082EFA98, 32'hEC4E6C89,
          32'h452821E6, 32'h38D01377, 32'hBE5466CF, 32'h34E90C6C,
          32'hC0AC29B7, 32'hC97C50DD, 32'h3F84D5B5, 32'hB5470917};
    return k[i];
  endfunction

  function automatic bit model_hit(input logic [15:0] nonce);
    logic [31:0] m [16];
    logic [31:0] v [16];
    logic [31:0] d0, d1;
    int a, b, c, d, x, y;
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    for (int i = 0; i < 4; i++) m[i] = stat[i];
    m[4] = upper; m[5] = {16'h0, nonce}; m[6] = 32'h80000000;
    m[13] = 32'h1; m[14] = LEN[63:32]; m[15] = LEN[31:0];
    for (int i = 0; i < 8; i++) v[i] = mid[i];
    for (int i = 0; i < 4; i++) v[8+i] = kc(i);
    v[12] = LEN[31:0] ^ kc(4);  v[13] = LEN[31:0] ^ kc(5);
    v[14] = LEN[63:32] ^ kc(6); v[15] = LEN[63:32] ^ kc(7);
    for (int r = 0; r < 14; r++) begin
      for (int i = 0; i < 8; i++) begin
        if (i < 4) begin a = i; b = i + 4; c = i + 8; d = i + 12; end
        else begin a = i - 4; b = 4 + (i - 3) % 4; c = 8 + (i - 2) % 4; d = 12 + (i - 1) % 4; end
        x = sg(r % 10, 2*i); y = sg(r % 10, 2*i + 1);
        v[a] = v[a] + v[b] + (m[x] ^ kc(y));
        v[d] = rr(v[d] ^ v[a], 16);
        v[c] = v[c] + v[d];
        v[b] = rr(v[b] ^ v[c], 12);
        v[a] = v[a] + v[b] + (m[y] ^ kc(x));
        v[d] = rr(v[d] ^ v[a], 8);
        v[c] = v[c] + v[d];
        v[b] = rr(v[b] ^ v[c], 7);
      end
    end
    d0 = mid[0] ^ v[0] ^ v[8];
    d1 = mid[1] ^ v[1] ^ v[9];
    return ((d0 >> (32 - TZB)) == 0) && ((d1 & mask) == 0);
  endfunction

  // predicts outcome and pushes it to the scoreboard
  task automatic predict(input string req, output int attempts);
    exp_t e;
    int n;
    n = nst;
    attempts = 0;
    e.req = req;
    forever begin
      attempts++;
      if (model_hit(16'(n))) begin
        e.kind = K_HIT; e.nonce = 16'(n); e.irq = 1'b1;
        break;
      end
      if (n + int'(strd) > 16'hFFFF || attempts > 600) begin
        e.kind = K_EXH; e.nonce = last_sol; e.irq = irq_o;
        break;
      end
      n = n + int'(strd);
    end
    e.cycles = 31 * attempts;
    if (e.kind == K_HIT) last_sol = e.nonce;
    q.push_back(e);
  endtask

  // ---------------- driver helpers ----------------
  task automatic wr(input int a, input logic [7:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = 6'(a); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_word(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) wr(a + i, w[31 - 8*i -: 8]);
  endtask

  task automatic load_cfg();
    for (int i = 0; i < 8; i++) wr_word(4*i, mid[i]);
    wr_word(32, mask);
    for (int i = 0; i < 4; i++) wr_word(36 + 4*i, stat[i]);
    wr_word(52, upper);
    wr(56, nst[15:8]); wr(57, nst[7:0]);
    wr(58, strd[15:8]); wr(59, strd[7:0]);
  endtask

  task automatic start_search();
    enable_i = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // ---------------- monitor ----------------
  initial begin
    int run = 0;
    logic pb = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk_i);
      if (busy_o) run++;
      else if (pb) begin
        if (q.size() == 0) chk(0, "R5 unexpected end", 32'(run), 0);
        else begin
          e = q.pop_front();
          chk(irq_o == e.irq, {e.req, " irq"}, 32'(irq_o), 32'(e.irq));
          chk(sol_nonce_o == e.nonce, {e.req, " sol"}, 32'(sol_nonce_o), 32'(e.nonce));
          chk(exhausted_o == (e.kind == K_EXH), {e.req, " exhausted"},
              32'(exhausted_o), 32'(e.kind == K_EXH));
          if (e.kind != K_ABORT)
            chk(run == e.cycles, {e.req, " R6 cycles"}, 32'(run), 32'(e.cycles));
        end
        run = 0;
      end
      pb = busy_o;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int k;
    exp_t e;
    for (int i = 0; i < 8; i++) mid[i] = 32'h6A09E667 ^ (32'(i + 1) * 32'h9E3779B9);
    for (int i = 0; i < 4; i++) stat[i] = 32'h0BADF00D + 32'(i) * 32'h01010101;
    upper = 32'h12345678; mask = 32'h80000000; nst = 16'h0100; strd = 16'd3;

    repeat (3) @(negedge clk_i);
    chk(irq_o == 0, "R1 irq", 32'(irq_o), 0);
    chk(busy_o == 0, "R1 busy", 32'(busy_o), 0);
    chk(exhausted_o == 0, "R1 exhausted", 32'(exhausted_o), 0);
    chk(sol_nonce_o == 0, "R1 sol", 32'(sol_nonce_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // search A: byte map, block layout, hit rule (R2 R3 R4 R5)
    load_cfg();
    predict("R2 R3 R4 R5 search A", k);
    start_search();
    wait_idle();
    repeat (10) @(negedge clk_i);
    chk(busy_o == 0, "R12 no restart while enable held", 32'(busy_o), 0);
    chk(irq_o == 1, "R7 irq sticky", 32'(irq_o), 1);
    irq_clr_i = 1'b1; @(negedge clk_i); irq_clr_i = 1'b0;
    chk(irq_o == 0, "R7 irq cleared", 32'(irq_o), 0);

    // search B: mask zero, other data and step (R4)
    mask = 32'h0; nst = 16'h0007; strd = 16'h1234; upper = 32'hCAFEBABE;
    stat[2] = 32'hFFFF0000;
    load_cfg();
    predict("R4 search B mask zero", k);
    start_search();
    wait_idle();

    // search C: writes during busy ignored, stray address ignored (R11)
    mask = 32'hC0000000; nst = 16'h4000; strd = 16'd11; mid[3] = 32'h01234567;
    load_cfg();
    for (int a = 60; a < 64; a++) wr(a, 8'hFF);
    predict("R11 search C busy writes", k);
    start_search();
    @(negedge clk_i);
    wr(56, 8'hAB); wr(57, 8'hCD); wr(32, 8'h00); wr(0, 8'h55);
    wait_idle();

    // search D: clear collides with new hit (R8); irq still set from C
    mask = 32'h80000000; nst = 16'h2000; strd = 16'd5; mid[0] = 32'hDEADBEEF;
    load_cfg();
    chk(irq_o == 1, "R8 irq preset", 32'(irq_o), 1);
    predict("R8 search D set beats clear", k);
    start_search();
    repeat (31 * k) @(negedge clk_i);
    irq_clr_i = 1'b1;
    @(negedge clk_i);
    irq_clr_i = 1'b0;
    wait_idle();
    chk(irq_o == 1, "R8 irq after collision", 32'(irq_o), 1);

    // search E: exhaustion (R9)
    irq_clr_i = 1'b1; @(negedge clk_i); irq_clr_i = 1'b0;
    mask = 32'hFFFFFFFF; nst = 16'hFFF0; strd = 16'd8;
    load_cfg();
    predict("R9 search E exhaustion", k);
    start_search();
    wait_idle();
    chk(irq_o == 0, "R9 no irq on exhaustion", 32'(irq_o), 0);

    // search F: abort, also clears exhausted on start (R9 R10)
    nst = 16'h0000; strd = 16'd1;
    load_cfg();
    e.kind = K_ABORT; e.nonce = last_sol; e.irq = irq_o; e.cycles = 0;
    e.req = "R10 abort";
    q.push_back(e);
    start_search();
    repeat (3) @(negedge clk_i);
    chk(exhausted_o == 0, "R9 exhausted cleared by start", 32'(exhausted_o), 0);
    repeat (40) @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 0, "R10 busy drops", 32'(busy_o), 0);
    repeat (40) @(negedge clk_i);
    chk(q.size() == 0, "R5 scoreboard drained", 32'(q.size()), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule